// File: doc/BRIEF.md
# Masked Fast GPIO Port

A general-purpose I/O port of parameterised width, 32 bits by default. A simple one-cycle register bus drives it. Each bit of the port has its own direction. The output latch can be changed in three ways: a whole-port write, a write that forces chosen bits high, and a write that forces chosen bits low. The two forcing writes let software change any group of bits in one access, with no read-modify-write. Every register accepts per-byte write strobes, so one access can be a byte, a halfword or a word.

A mask register groups bits. A bit whose mask is 1 is protected: port-value, set and clear writes leave it alone, and it reads as 0 from the pin-level register. Pin inputs pass through a synchronizer before software can see them. The output enable of each pad follows its direction bit. The pad data comes straight from the output latch.

Registers, by word index on `bus_addr`: 0 direction, 1 mask, 2 pin level (read) / port value (write), 3 set (reads back the output latch), 4 clear (reads back the output latch). Indices 5 to 7 are unused.

Top module: `mgp_port`

## Requirements
- R1: While reset is asserted, and at its release, the direction, mask and output latch are all 0: `pin_oe` and `pin_o` are 0 and every register reads 0.
- R2: A write to index 0 loads the direction register in the enabled byte lanes. Bit value 1 means output, and `pin_oe` equals the direction register.
- R3: A write to index 2 replaces the output latch bits that are unmasked and in enabled lanes with the written data.
- R4: A write to index 3 sets to 1 each unmasked, lane-enabled latch bit written as 1. Bits written as 0 keep their value.
- R5: A write to index 4 clears to 0 each unmasked, lane-enabled latch bit written as 1. Bits written as 0 keep their value.
- R6: A mask bit of 1 keeps that latch bit unchanged through writes to index 2, 3 and 4. Writes to index 0 and 1 are not masked.
- R7: `bus_be[k]` enables bits 8k+7..8k. A lane whose strobe is 0 keeps its value in every register, and a write with no strobe changes nothing.
- R8: A read of index 2 returns the pin levels from two clock edges earlier (with two synchronizer stages), with masked bits read as 0.
- R9: Reads of index 0 and 1 return the direction and mask registers. Reads of index 3 and 4 return the output latch. Reads of index 5 to 7 return 0, and writes to them change nothing.
- R10: `pin_o` always equals the output latch, whatever the direction bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_be | input | WIDTH/8 | Byte-lane write strobes |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, combinational from bus_addr |
| pin_i | input | WIDTH | Pad input levels |
| pin_o | output | WIDTH | Pad output data |
| pin_oe | output | WIDTH | Pad output enable, 1 = drive |

## Verification
The bench uses the defaults: a 32-bit port, four byte lanes and two synchronizer stages. Four lanes make the non-contiguous strobe patterns (lanes 3 and 1 only, for example) visible against a mask that covers some lanes and not others. Two stages make the exact two-edge pin-read latency observable cycle by cycle. The vectors walk the latch through set, clear and whole-port writes under a changing mask, so that the protected and unprotected bits can be told apart at every step.

// File: rtl/mgp_pkg.sv
package mgp_pkg;

  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RG_DIR  = 3'd0,
    RG_MASK = 3'd1,
    RG_PVAL = 3'd2,
    RG_SET  = 3'd3,
    RG_CLR  = 3'd4
  } reg_idx_e;

endpackage

// File: rtl/mgp_sync.sv
module mgp_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];

endmodule

// File: rtl/mgp_regfile.sv
module mgp_regfile
  import mgp_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int NBYTE = WIDTH / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBYTE-1:0]  be,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  mask_q,
  output logic [WIDTH-1:0]  out_q,
  output logic              wr_dir,
  output logic              wr_mask,
  output logic              wr_pval,
  output logic              wr_set,
  output logic              wr_clr,
  output logic [WIDTH-1:0]  lane_bits
);

  // Spread the byte strobes over the bits they cover.
  function automatic logic [WIDTH-1:0] spread_lanes(input logic [NBYTE-1:0] strobes);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) r[i] = strobes[i/8];
    return r;
  endfunction

  // Keep old bits outside sel, take new bits inside sel.
  function automatic logic [WIDTH-1:0] merge_sel(input logic [WIDTH-1:0] old_v,
                                                 input logic [WIDTH-1:0] new_v,
                                                 input logic [WIDTH-1:0] sel);
    return (old_v & ~sel) | (new_v & sel);
  endfunction

  // Latch update from force-high and force-low vectors; low wins.
  function automatic logic [WIDTH-1:0] force_bits(input logic [WIDTH-1:0] cur,
                                                  input logic [WIDTH-1:0] hi_v,
                                                  input logic [WIDTH-1:0] lo_v);
    return (cur | hi_v) & ~lo_v;
  endfunction

  logic [WIDTH-1:0] eff_bits;   // lane-enabled and unmasked
  logic [WIDTH-1:0] hi_v, lo_v;
  logic [WIDTH-1:0] out_nxt;

  assign lane_bits = spread_lanes(be);
  assign eff_bits  = lane_bits & ~mask_q;

  assign wr_dir  = wr_en && (addr == RG_DIR);
  assign wr_mask = wr_en && (addr == RG_MASK);
  assign wr_pval = wr_en && (addr == RG_PVAL);
  assign wr_set  = wr_en && (addr == RG_SET);
  assign wr_clr  = wr_en && (addr == RG_CLR);

  always_comb begin
    hi_v = '0;
    lo_v = '0;
    if (wr_pval) begin
      hi_v = wdata & eff_bits;
      lo_v = ~wdata & eff_bits;
    end else if (wr_set) begin
      hi_v = wdata & eff_bits;
    end else if (wr_clr) begin
      lo_v = wdata & eff_bits;
    end
    out_nxt = force_bits(out_q, hi_v, lo_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      mask_q <= '0;
      out_q  <= '0;
    end else begin
      if (wr_dir)  dir_q  <= merge_sel(dir_q, wdata, lane_bits);
      if (wr_mask) mask_q <= merge_sel(mask_q, wdata, lane_bits);
      out_q <= out_nxt;
    end
  end

endmodule

// File: rtl/mgp_rdmux.sv
module mgp_rdmux
  import mgp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  dir_q,
  input  logic [WIDTH-1:0]  mask_q,
  input  logic [WIDTH-1:0]  out_q,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  rdata
);

  always_comb begin
    case (addr)
      RG_DIR:         rdata = dir_q;
      RG_MASK:        rdata = mask_q;
      RG_PVAL:        rdata = pin_sync & ~mask_q;
      RG_SET, RG_CLR: rdata = out_q;
      default:        rdata = '0;
    endcase
  end

endmodule

// File: rtl/mgp_port.sv
module mgp_port
  import mgp_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WIDTH/8-1:0] bus_be,
  input  logic [WIDTH-1:0]   bus_wdata,
  output logic [WIDTH-1:0]   bus_rdata,
  input  logic [WIDTH-1:0]   pin_i,
  output logic [WIDTH-1:0]   pin_o,
  output logic [WIDTH-1:0]   pin_oe
);

  localparam int NBYTE = WIDTH / 8;

  logic             wr_en;
  logic [WIDTH-1:0] dir_q, mask_q, out_q, pin_sync, lane_bits;
  logic             wr_dir, wr_mask, wr_pval, wr_set, wr_clr;

  assign wr_en = bus_sel && bus_wr;

  mgp_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pin_i),
    .d_out (pin_sync)
  );

  mgp_regfile #(.WIDTH(WIDTH), .NBYTE(NBYTE)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (bus_addr),
    .be        (bus_be),
    .wdata     (bus_wdata),
    .dir_q     (dir_q),
    .mask_q    (mask_q),
    .out_q     (out_q),
    .wr_dir    (wr_dir),
    .wr_mask   (wr_mask),
    .wr_pval   (wr_pval),
    .wr_set    (wr_set),
    .wr_clr    (wr_clr),
    .lane_bits (lane_bits)
  );

  mgp_rdmux #(.WIDTH(WIDTH)) u_rd (
    .addr     (bus_addr),
    .dir_q    (dir_q),
    .mask_q   (mask_q),
    .out_q    (out_q),
    .pin_sync (pin_sync),
    .rdata    (bus_rdata)
  );

  assign pin_o  = out_q;
  assign pin_oe = dir_q;

endmodule

// File: rtl/mgp_port_chk.sv
module mgp_port_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_dir,
  input logic             wr_mask,
  input logic             wr_pval,
  input logic             wr_set,
  input logic             wr_clr,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [2:0]       bus_addr,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] lane_bits,
  input logic [WIDTH-1:0] mask_q,
  input logic [WIDTH-1:0] pin_o,
  input logic [WIDTH-1:0] pin_oe
);

  logic port_wr;
  assign port_wr = wr_pval || wr_set || wr_clr;

  // R1: outputs are clear on the edge after reset is seen low
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_o == '0));

  // R4: set bits that are enabled and unmasked read 1 afterwards
  a_r4_set_hits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((pin_o & $past(bus_wdata & lane_bits & ~mask_q))
                == $past(bus_wdata & lane_bits & ~mask_q)));

  // R5: cleared bits that are enabled and unmasked read 0 afterwards
  a_r5_clr_hits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((pin_o & $past(bus_wdata & lane_bits & ~mask_q)) == '0));

  // R6: protected bits keep their value through port writes
  a_r6_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> (((pin_o ^ $past(pin_o)) & $past(mask_q)) == '0));

  // R7: lanes without a strobe keep their output value
  a_r7_lane_holds: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> (((pin_o ^ $past(pin_o)) & ~$past(lane_bits)) == '0));

  // R2: the enable only moves on a direction write
  a_r2_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(pin_oe));

  // R9: unused indices change nothing
  a_r9_unused_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr > 3'd4) |=> ($stable(pin_o) && $stable(pin_oe)));

  // R10: the latch only moves on a port write
  a_r10_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !port_wr |=> $stable(pin_o));

  // at most one decoded write strobe at a time
  a_r9_one_decode: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_dir, wr_mask, wr_pval, wr_set, wr_clr}));

endmodule

bind mgp_port mgp_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_dir    (wr_dir),
  .wr_mask   (wr_mask),
  .wr_pval   (wr_pval),
  .wr_set    (wr_set),
  .wr_clr    (wr_clr),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .lane_bits (lane_bits),
  .mask_q    (mask_q),
  .pin_o     (pin_o),
  .pin_oe    (pin_oe)
);

// File: tb/mgp_port_tb.sv
module mgp_port_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_i = '0;
  logic [31:0] pin_o, pin_oe;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  mgp_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  // {req, wr index, strobes, data, read index, expected read}
  localparam logic [77:0] VEC [0:11] = '{
    {4'd2,  3'd0, 4'hF, 32'h0000_FFFF, 3'd0, 32'h0000_FFFF}, // R2
    {4'd3,  3'd2, 4'hF, 32'hA5A5_1234, 3'd3, 32'hA5A5_1234}, // R3
    {4'd4,  3'd3, 4'hF, 32'h0F00_0000, 3'd3, 32'hAFA5_1234}, // R4
    {4'd5,  3'd4, 4'hF, 32'h0000_0034, 3'd4, 32'hAFA5_1200}, // R5
    {4'd9,  3'd1, 4'hF, 32'hFFFF_0000, 3'd1, 32'hFFFF_0000}, // R9
    {4'd6,  3'd2, 4'hF, 32'h0000_0000, 3'd3, 32'hAFA5_0000}, // R6
    {4'd6,  3'd3, 4'hF, 32'hFFFF_FFFF, 3'd3, 32'hAFA5_FFFF}, // R6
    {4'd6,  3'd4, 4'hF, 32'hFFFF_FFFF, 3'd3, 32'hAFA5_0000}, // R6
    {4'd7,  3'd1, 4'h8, 32'h0000_0000, 3'd1, 32'h00FF_0000}, // R7
    {4'd7,  3'd2, 4'hA, 32'h1111_2222, 3'd3, 32'h11A5_2200}, // R7
    {4'd9,  3'd5, 4'hF, 32'hFFFF_FFFF, 3'd5, 32'h0000_0000}, // R9
    {4'd7,  3'd3, 4'h0, 32'hFFFF_FFFF, 3'd4, 32'h11A5_2200}  // R7
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 oe", pin_oe, 32'h0);
    chk("R1 out", pin_o, 32'h0);
    for (int a = 0; a < 5; a++) rd_chk(3'(a), 32'h0, "R1 reg");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", pin_o, 32'h0);

    for (int i = 0; i < 12; i++) begin
      do_wr(VEC[i][73:71], VEC[i][70:67], VEC[i][66:35]);
      rd_chk(VEC[i][34:32], VEC[i][31:0], $sformatf("R%0d vec %0d", VEC[i][77:74], i));
    end

    // R2 / R10: pads follow direction and latch
    chk("R2 pin_oe", pin_oe, 32'h0000_FFFF);
    chk("R10 pin_o", pin_o, 32'h11A5_2200);

    // R2: direction write through one lane only
    do_wr(3'd0, 4'h4, 32'h00AB_0000);
    chk("R2 lane oe", pin_oe, 32'h00AB_FFFF);
    chk("R10 pin_o kept", pin_o, 32'h11A5_2200);

    // R8: two-edge latency of pin reads
    do_wr(3'd1, 4'hF, 32'h0);
    pin_i = 32'hDEAD_BEEF;
    @(negedge clk);
    rd_chk(3'd2, 32'h0, "R8 one edge");
    @(negedge clk);
    rd_chk(3'd2, 32'hDEAD_BEEF, "R8 two edges");
    do_wr(3'd1, 4'hF, 32'hF0F0_F0F0);
    rd_chk(3'd2, 32'h0E0D_0E0F, "R8 masked read");

    // R5 / R6: clear leaves protected nibbles alone
    do_wr(3'd4, 4'hF, 32'hFFFF_FFFF);
    chk("R6 clr masked", pin_o, 32'h10A0_2000);

    // R1: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 mid oe", pin_oe, 32'h0);
    chk("R1 mid out", pin_o, 32'h0);
    rd_chk(3'd1, 32'h0, "R1 mid mask");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule